// File: doc/BRIEF.md
# Store Queue with Commit-Gated Writeback

This block holds the stores of an out-of-order core between dispatch and memory. Stores enter in program order, each carrying a sequence number, and take the slot the block reports as its tail index. When a store executes, the core writes its address, byte size, data and two flags into that slot: one for a store-conditional and one for a prefetch-type store. Stores stay speculative until the commit stage reports the youngest committed sequence number. From then on they may write back.

A writeback pointer, kept apart from the head, walks the eligible stores in order. It presents each one on a valid/ready write port. A store whose size is zero, or which is a prefetch, finishes at the pointer without a memory request. A real store finishes when the memory side reports completion for its slot. Completions can arrive out of order. The head frees the oldest run of finished slots in a single cycle. After a misprediction, a squash removes the younger speculative stores from the tail end. It never removes a store that has already been cleared for writeback.

The ring has one more slot than the usable depth, so a full queue and an empty queue need no extra flag to tell them apart.

Top module: `store_queue_wb`

## Requirements
- R1: After reset the queue is empty: occupancy 0, allocation index 0, allocation ready high, no write request.
- R2: The ring has DEPTH+1 slots and holds at most DEPTH stores. Allocation ready is low when tail+1 (mod DEPTH+1) equals head. An allocation offered while the queue is full is ignored. The allocation index steps from slot DEPTH to slot 0.
- R3: A commit walks from head toward tail. It marks every not-yet-eligible store with sequence number at or below the committed number, and stops at the first unmarked store that is younger. Stores beyond that point produce no write request.
- R4: A store-conditional with nonzero size becomes eligible when it executes, with no commit needed.
- R5: Eligible stores leave in ring order, at most one per cycle. The write request carries the slot index, address, size and data recorded at execute. The pointer advances only on a cycle with both valid and ready high.
- R6: While valid is high and ready is low, the request and all its fields stay unchanged.
- R7: An eligible zero-size store produces no write request. It completes and is freed in the next cycle.
- R8: An eligible prefetch-type store (prefetch flag = 1) uses its cycle at the pointer, produces no write request, and completes.
- R9: A completion for a slot that is not the head frees nothing. When the head completes, the head moves past it and every following completed slot in one cycle.
- R10: A squash removes stores from the tail backward while their sequence number is greater than the squash number. It stops at the first store already eligible, even a younger one. The next allocation index equals the oldest removed slot.
- R11: Allocation ready is low in any cycle that carries a squash, and an allocation offered then is ignored.
- R12: The occupancy output equals the number of stores allocated and not yet freed or squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid_i | input | 1 | Allocate a store at the tail |
| alloc_seq_i | input | SEQ_W | Sequence number of the new store |
| alloc_ready_o | output | 1 | Allocation accepted this cycle |
| alloc_idx_o | output | IDX_W | Slot the next allocation takes |
| exe_valid_i | input | 1 | Execute update for one slot |
| exe_idx_i | input | IDX_W | Slot being updated |
| exe_addr_i | input | ADDR_W | Store address |
| exe_size_i | input | SIZE_W | Store size in bytes, 0 for no data |
| exe_data_i | input | DATA_W | Store data |
| exe_cond_i | input | 1 | Store-conditional flag |
| exe_pref_i | input | 1 | Prefetch-type store flag |
| cmt_valid_i | input | 1 | Commit report valid |
| cmt_seq_i | input | SEQ_W | Youngest committed sequence number |
| sqh_valid_i | input | 1 | Squash request |
| sqh_seq_i | input | SEQ_W | Stores younger than this are removed |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory accepts the write request |
| wr_idx_o | output | IDX_W | Slot of the write request |
| wr_addr_o | output | ADDR_W | Write address |
| wr_size_o | output | SIZE_W | Write size in bytes |
| wr_data_o | output | DATA_W | Write data |
| wr_done_i | input | 1 | A written store has completed |
| wr_done_idx_i | input | IDX_W | Slot of the completed store |
| occupancy_o | output | CNT_W | Stores currently held |

## Verification
A corrupted head or tail shows up at once as a wrong allocation index or a wrong occupancy on the next sampled cycle. A lost or duplicated eligibility mark shows up as a write request that is missing or out of order in the cycle right after the commit, conditional execute or handshake. A head that does not skip over completed slots leaves the occupancy too high in the cycle after the head completes. A squash that walks too far shows as a lost request after the later commit. Each scenario therefore checks occupancy, allocation index and the request fields in the first cycle after the registered event.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef enum logic [1:0] {
    WB_IDLE,
    WB_ZERO,
    WB_PREF,
    WB_SEND
  } wb_act_e;

  // forward step on the ring
  function automatic int unsigned ring_add(int unsigned i, int unsigned k,
                                           int unsigned slots);
    return (i + k) % slots;
  endfunction

  // backward step on the ring
  function automatic int unsigned ring_sub(int unsigned i, int unsigned k,
                                           int unsigned slots);
    return (i + slots - (k % slots)) % slots;
  endfunction

  // number of slots from 'from' up to (not including) 'to'
  function automatic int unsigned ring_dist(int unsigned from, int unsigned to,
                                            int unsigned slots);
    return (to + slots - from) % slots;
  endfunction

  function automatic bit ring_full(int unsigned head, int unsigned tail,
                                   int unsigned slots);
    return ring_add(tail, 1, slots) == head;
  endfunction

endpackage

// File: rtl/sq_commit_scan.sv
module sq_commit_scan #(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3,
  parameter int SEQ_W = 8
) (
  input  logic             cmt_valid_i,
  input  logic [SEQ_W-1:0] cmt_seq_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic [IDX_W-1:0] tail_i,
  input  logic [SLOTS-1:0] elig_i,
  input  logic [SEQ_W-1:0] seq_i [SLOTS],
  output logic [SLOTS-1:0] mark_o
);

  always_comb begin
    logic             halt;
    logic [IDX_W-1:0] p;
    mark_o = '0;
    halt   = !cmt_valid_i;
    p      = head_i;
    for (int k = 0; k < SLOTS; k++) begin
      p = IDX_W'(sq_pkg::ring_add(32'(head_i), unsigned'(k), SLOTS));
      if (!halt) begin
        if (p == tail_i) begin
          halt = 1'b1;
        end else if (!elig_i[p]) begin
          if (seq_i[p] > cmt_seq_i) halt = 1'b1;
          else mark_o[p] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sq_squash_scan.sv
module sq_squash_scan #(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3,
  parameter int SEQ_W = 8
) (
  input  logic             sqh_valid_i,
  input  logic [SEQ_W-1:0] sqh_seq_i,
  input  logic [IDX_W-1:0] tail_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SLOTS-1:0] elig_i,
  input  logic [SEQ_W-1:0] seq_i [SLOTS],
  output logic [SLOTS-1:0] kill_o,
  output logic [CNT_W-1:0] kill_n_o,
  output logic [IDX_W-1:0] tail_o
);

  always_comb begin
    logic             halt;
    logic [IDX_W-1:0] p;
    int               nk;
    kill_o = '0;
    tail_o = tail_i;
    halt   = !sqh_valid_i;
    nk     = 0;
    p      = tail_i;
    for (int k = 0; k < SLOTS; k++) begin
      p = IDX_W'(sq_pkg::ring_sub(32'(tail_i), unsigned'(k + 1), SLOTS));
      if (!halt) begin
        if (k < int'(cnt_i) && !elig_i[p] && seq_i[p] > sqh_seq_i) begin
          kill_o[p] = 1'b1;
          tail_o    = p;
          nk        = nk + 1;
        end else begin
          halt = 1'b1;
        end
      end
    end
    kill_n_o = CNT_W'(nk);
  end

endmodule

// File: rtl/sq_retire.sv
module sq_retire #(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic [IDX_W-1:0] head_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SLOTS-1:0] done_i,
  output logic [SLOTS-1:0] free_o,
  output logic [CNT_W-1:0] pop_n_o,
  output logic [IDX_W-1:0] head_o
);

  always_comb begin
    logic             halt;
    logic [IDX_W-1:0] p;
    int               np;
    free_o = '0;
    halt   = 1'b0;
    np     = 0;
    p      = head_i;
    for (int k = 0; k < SLOTS; k++) begin
      p = IDX_W'(sq_pkg::ring_add(32'(head_i), unsigned'(k), SLOTS));
      if (!halt) begin
        if (k < int'(cnt_i) && done_i[p]) begin
          free_o[p] = 1'b1;
          np        = np + 1;
        end else begin
          halt = 1'b1;
        end
      end
    end
    pop_n_o = CNT_W'(np);
    head_o  = IDX_W'(sq_pkg::ring_add(32'(head_i), unsigned'(np), SLOTS));
  end

endmodule

// File: rtl/sq_wb_engine.sv
module sq_wb_engine #(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] tail_i,
  input  logic [SLOTS-1:0] valid_i,
  input  logic [SLOTS-1:0] elig_i,
  input  logic [SLOTS-1:0] zero_i,
  input  logic [SLOTS-1:0] pref_i,
  input  logic             pend_nz_i,
  input  logic             ready_i,
  output logic [IDX_W-1:0] wb_o,
  output logic             req_valid_o,
  output logic             local_done_o
);

  sq_pkg::wb_act_e  act;
  logic [IDX_W-1:0] wb_q;
  logic             entry_ok;
  logic             adv;

  assign entry_ok = (wb_q != tail_i) && valid_i[wb_q] && elig_i[wb_q] && pend_nz_i;

  always_comb begin
    if (!entry_ok)          act = sq_pkg::WB_IDLE;
    else if (zero_i[wb_q])  act = sq_pkg::WB_ZERO;
    else if (pref_i[wb_q])  act = sq_pkg::WB_PREF;
    else                    act = sq_pkg::WB_SEND;
  end

  assign req_valid_o  = (act == sq_pkg::WB_SEND);
  assign local_done_o = (act == sq_pkg::WB_ZERO) || (act == sq_pkg::WB_PREF);
  assign adv          = local_done_o || (req_valid_o && ready_i);
  assign wb_o         = wb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wb_q <= '0;
    else if (adv) wb_q <= IDX_W'(sq_pkg::ring_add(32'(wb_q), 1, SLOTS));
  end

  // R6: a pending request is not withdrawn and its slot does not move
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !ready_i |=> req_valid_o && $stable(wb_q));

endmodule

// File: rtl/store_queue_wb.sv
module store_queue_wb #(
  parameter int DEPTH  = 4,
  parameter int SEQ_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  localparam int SLOTS = DEPTH + 1,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid_i,
  input  logic [SEQ_W-1:0]  alloc_seq_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              exe_valid_i,
  input  logic [IDX_W-1:0]  exe_idx_i,
  input  logic [ADDR_W-1:0] exe_addr_i,
  input  logic [SIZE_W-1:0] exe_size_i,
  input  logic [DATA_W-1:0] exe_data_i,
  input  logic              exe_cond_i,
  input  logic              exe_pref_i,
  input  logic              cmt_valid_i,
  input  logic [SEQ_W-1:0]  cmt_seq_i,
  input  logic              sqh_valid_i,
  input  logic [SEQ_W-1:0]  sqh_seq_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [SIZE_W-1:0] wr_size_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_done_i,
  input  logic [IDX_W-1:0]  wr_done_idx_i,
  output logic [CNT_W-1:0]  occupancy_o
);

  // slot storage
  logic [SLOTS-1:0]  v_q, el_q, dn_q, pf_q;
  logic [SEQ_W-1:0]  seq_q  [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [SIZE_W-1:0] size_q [SLOTS];
  logic [DATA_W-1:0] data_q [SLOTS];

  logic [IDX_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q, pend_q;

  // internal events, named for the checks
  logic              full_w;
  logic              alloc_fire;
  logic              cond_mark;
  logic [SLOTS-1:0]  mark_w, kill_w, free_w, done_next, zero_w;
  logic [CNT_W-1:0]  kill_n, pop_n;
  logic [IDX_W-1:0]  sq_tail, ret_head, wb_idx;
  logic              local_done;

  assign full_w        = sq_pkg::ring_full(32'(head_q), 32'(tail_q), SLOTS);
  assign alloc_ready_o = !full_w && !sqh_valid_i;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;
  assign alloc_idx_o   = tail_q;
  assign occupancy_o   = cnt_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_zero
    assign zero_w[g] = (size_q[g] == '0);
  end

  sq_commit_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_commit (
    .cmt_valid_i (cmt_valid_i),
    .cmt_seq_i   (cmt_seq_i),
    .head_i      (head_q),
    .tail_i      (tail_q),
    .elig_i      (el_q),
    .seq_i       (seq_q),
    .mark_o      (mark_w)
  );

  sq_squash_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_squash (
    .sqh_valid_i (sqh_valid_i),
    .sqh_seq_i   (sqh_seq_i),
    .tail_i      (tail_q),
    .cnt_i       (cnt_q),
    .elig_i      (el_q),
    .seq_i       (seq_q),
    .kill_o      (kill_w),
    .kill_n_o    (kill_n),
    .tail_o      (sq_tail)
  );

  sq_wb_engine #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_wb (
    .clk          (clk),
    .rst_n        (rst_n),
    .tail_i       (tail_q),
    .valid_i      (v_q),
    .elig_i       (el_q),
    .zero_i       (zero_w),
    .pref_i       (pf_q),
    .pend_nz_i    (pend_q != '0),
    .ready_i      (wr_ready_i),
    .wb_o         (wb_idx),
    .req_valid_o  (wr_valid_o),
    .local_done_o (local_done)
  );

  // completion vector seen by the head logic this cycle
  always_comb begin
    done_next = dn_q;
    if (local_done) done_next[wb_idx] = 1'b1;
    if (wr_done_i)  done_next[wr_done_idx_i] = 1'b1;
  end

  sq_retire #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_retire (
    .head_i  (head_q),
    .cnt_i   (cnt_q),
    .done_i  (done_next),
    .free_o  (free_w),
    .pop_n_o (pop_n),
    .head_o  (ret_head)
  );

  assign cond_mark = exe_valid_i && exe_cond_i && (exe_size_i != '0) &&
                     v_q[exe_idx_i] && !el_q[exe_idx_i] && !mark_w[exe_idx_i];

  assign wr_idx_o  = wb_idx;
  assign wr_addr_o = addr_q[wb_idx];
  assign wr_size_o = size_q[wb_idx];
  assign wr_data_o = data_q[wb_idx];

  // pointers and counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      head_q <= ret_head;
      if (kill_n != '0)    tail_q <= sq_tail;
      else if (alloc_fire) tail_q <= IDX_W'(sq_pkg::ring_add(32'(tail_q), 1, SLOTS));
      cnt_q  <= CNT_W'(int'(cnt_q) + int'(alloc_fire) - int'(pop_n) - int'(kill_n));
      pend_q <= CNT_W'(int'(pend_q) + $countones(mark_w) + int'(cond_mark)
                       - int'(local_done) - int'(wr_done_i));
    end
  end

  // per-slot state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      el_q <= '0;
      dn_q <= '0;
      pf_q <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        seq_q[i]  <= '0;
        addr_q[i] <= '0;
        size_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        dn_q[i] <= done_next[i];
        if (mark_w[i]) el_q[i] <= 1'b1;
        if (exe_valid_i && exe_idx_i == IDX_W'(i)) begin
          addr_q[i] <= exe_addr_i;
          size_q[i] <= exe_size_i;
          data_q[i] <= exe_data_i;
          pf_q[i]   <= exe_pref_i;
          if (cond_mark) el_q[i] <= 1'b1;
        end
        if (kill_w[i] || free_w[i]) begin
          v_q[i]  <= 1'b0;
          el_q[i] <= 1'b0;
          dn_q[i] <= 1'b0;
        end
        if (alloc_fire && tail_q == IDX_W'(i)) begin
          v_q[i]    <= 1'b1;
          el_q[i]   <= 1'b0;
          dn_q[i]   <= 1'b0;
          pf_q[i]   <= 1'b0;
          size_q[i] <= '0;
          seq_q[i]  <= alloc_seq_i;
        end
      end
    end
  end

  // R2: occupancy never exceeds the usable depth
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  // R12: head/tail distance and occupancy agree
  a_r12_ring_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    sq_pkg::ring_dist(32'(head_q), 32'(tail_q), SLOTS) == 32'(cnt_q));

  // R5: writeback pointer stays between head and tail
  a_r5_wb_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    sq_pkg::ring_dist(32'(head_q), 32'(wb_idx), SLOTS) <= 32'(cnt_q));

  // R9: after each cycle the head slot is never a finished one
  a_r9_head_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0 |-> !dn_q[head_q]);

  // R6: request fields hold while waiting for ready
  a_r6_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_size_o));

endmodule

// File: tb/test_store_queue_wb.sv
`timescale 1ns/1ps
module test_store_queue_wb;

  localparam int DEPTH = 4;
  localparam int SEQ_W = 8, ADDR_W = 16, DATA_W = 32, SIZE_W = 4;
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0; logic [SEQ_W-1:0] alloc_seq = '0;
  logic alloc_ready; logic [IDX_W-1:0] alloc_idx;
  logic exe_valid = 1'b0; logic [IDX_W-1:0] exe_idx = '0;
  logic [ADDR_W-1:0] exe_addr = '0; logic [SIZE_W-1:0] exe_size = '0;
  logic [DATA_W-1:0] exe_data = '0; logic exe_cond = 1'b0, exe_pref = 1'b0;
  logic cmt_valid = 1'b0; logic [SEQ_W-1:0] cmt_seq = '0;
  logic sqh_valid = 1'b0; logic [SEQ_W-1:0] sqh_seq = '0;
  logic wr_valid, wr_ready = 1'b0;
  logic [IDX_W-1:0] wr_idx; logic [ADDR_W-1:0] wr_addr;
  logic [SIZE_W-1:0] wr_size; logic [DATA_W-1:0] wr_data;
  logic wr_done = 1'b0; logic [IDX_W-1:0] wr_done_idx = '0;
  logic [CNT_W-1:0] occupancy;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  store_queue_wb #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
                   .DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_store_queue_wb (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_seq_i(alloc_seq),
    .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .exe_valid_i(exe_valid), .exe_idx_i(exe_idx), .exe_addr_i(exe_addr),
    .exe_size_i(exe_size), .exe_data_i(exe_data), .exe_cond_i(exe_cond),
    .exe_pref_i(exe_pref), .cmt_valid_i(cmt_valid), .cmt_seq_i(cmt_seq),
    .sqh_valid_i(sqh_valid), .sqh_seq_i(sqh_seq),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_idx_o(wr_idx),
    .wr_addr_o(wr_addr), .wr_size_o(wr_size), .wr_data_o(wr_data),
    .wr_done_i(wr_done), .wr_done_idx_i(wr_done_idx), .occupancy_o(occupancy)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock, inputs change 1 ns after the edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_alloc(int seq);
    alloc_valid = 1'b1; alloc_seq = SEQ_W'(seq);
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic do_exe(int idx, int addr, int size, int data, bit cond, bit pref);
    exe_valid = 1'b1; exe_idx = IDX_W'(idx); exe_addr = ADDR_W'(addr);
    exe_size = SIZE_W'(size); exe_data = DATA_W'(data);
    exe_cond = cond; exe_pref = pref;
    step();
    exe_valid = 1'b0; exe_cond = 1'b0; exe_pref = 1'b0;
  endtask

  task automatic do_commit(int seq);
    cmt_valid = 1'b1; cmt_seq = SEQ_W'(seq);
    step();
    cmt_valid = 1'b0;
  endtask

  task automatic do_squash(int seq);
    sqh_valid = 1'b1; sqh_seq = SEQ_W'(seq);
    step();
    sqh_valid = 1'b0;
  endtask

  task automatic do_done(int idx);
    wr_done = 1'b1; wr_done_idx = IDX_W'(idx);
    step();
    wr_done = 1'b0;
  endtask

  task automatic do_take();
    wr_ready = 1'b1;
    step();
    wr_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 occupancy", occupancy, 0);
    chk("R1 alloc_idx", alloc_idx, 0);
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 wr_valid", wr_valid, 0);
  endtask

  task automatic t_fill_and_flush();
    for (int i = 0; i < DEPTH; i++) begin
      do_alloc(i + 1);
      chk("R12 occupancy on fill", occupancy, i + 1);
    end
    chk("R2 alloc_idx at last slot", alloc_idx, DEPTH);
    chk("R2 alloc_ready when full", alloc_ready, 0);
    do_alloc(99);
    chk("R2 full alloc ignored", occupancy, DEPTH);
    do_squash(0);
    chk("R10 squash all occupancy", occupancy, 0);
    chk("R10 tail back to oldest removed", alloc_idx, 0);
    chk("R10 no request after squash", wr_valid, 0);
  endtask

  task automatic t_commit_order();
    do_alloc(10); do_alloc(11); do_alloc(12);
    for (int i = 0; i < 3; i++) do_exe(i, 'h100 + i, 4, 'hA0 + i, 1'b0, 1'b0);
    chk("R3 nothing before commit", wr_valid, 0);
    do_commit(11);
    chk("R5 first request valid", wr_valid, 1);
    chk("R5 first request idx", wr_idx, 0);
    chk("R5 first request addr", wr_addr, 'h100);
    chk("R5 first request data", wr_data, 'hA0);
    chk("R5 first request size", wr_size, 4);
    for (int c = 0; c < 3; c++) begin
      step();
      chk("R6 held valid", wr_valid, 1);
      chk("R6 held idx", wr_idx, 0);
      chk("R6 held addr", wr_addr, 'h100);
    end
    do_take();
    chk("R5 second request idx", wr_idx, 1);
    chk("R5 second request data", wr_data, 'hA1);
    do_take();
    chk("R3 uncommitted store held back", wr_valid, 0);
    do_done(0);
    chk("R9 head completion frees", occupancy, 2);
    do_done(1);
    chk("R9 second completion frees", occupancy, 1);
    do_commit(12);
    chk("R3 later commit releases", wr_idx, 2);
    chk("R3 later commit valid", wr_valid, 1);
    do_take();
    do_done(2);
    chk("R12 drained", occupancy, 0);
  endtask

  task automatic t_conditional();
    do_alloc(20);
    chk("R4 slot", alloc_idx, 4);
    do_exe(3, 'h300, 2, 'hC3, 1'b1, 1'b0);
    chk("R4 conditional request without commit", wr_valid, 1);
    chk("R4 conditional idx", wr_idx, 3);
    chk("R4 conditional size", wr_size, 2);
    do_take();
    do_done(3);
    chk("R4 conditional freed", occupancy, 0);
  endtask

  task automatic t_zero_and_prefetch();
    do_alloc(30);
    chk("R2 index wraps to slot 0", alloc_idx, 0);
    do_alloc(31); do_alloc(32);
    do_exe(4, 'h400, 0, 'h0, 1'b0, 1'b0);
    do_exe(0, 'h410, 4, 'h11, 1'b0, 1'b1);
    do_exe(1, 'h500, 8, 'h55, 1'b0, 1'b0);
    do_commit(32);
    chk("R7 zero-size sends nothing", wr_valid, 0);
    chk("R7 occupancy before", occupancy, 3);
    step();
    chk("R7 zero-size freed", occupancy, 2);
    chk("R8 prefetch sends nothing", wr_valid, 0);
    step();
    chk("R8 prefetch freed", occupancy, 1);
    chk("R8 next request valid", wr_valid, 1);
    chk("R8 next request idx", wr_idx, 1);
    chk("R8 next request addr", wr_addr, 'h500);
    chk("R8 next request size", wr_size, 8);
    do_take();
    do_done(1);
    chk("R12 empty again", occupancy, 0);
  endtask

  task automatic t_head_jump();
    do_alloc(40); do_alloc(41); do_alloc(42);
    for (int i = 0; i < 3; i++) do_exe(2 + i, 'h600 + i, 4, 'hD0 + i, 1'b0, 1'b0);
    do_commit(42);
    for (int i = 0; i < 3; i++) begin
      chk("R5 in-order idx", wr_idx, 2 + i);
      do_take();
    end
    chk("R5 all sent", wr_valid, 0);
    do_done(4);
    chk("R9 young completion frees nothing", occupancy, 3);
    do_done(3);
    chk("R9 middle completion frees nothing", occupancy, 3);
    do_done(2);
    chk("R9 head jumps over completed run", occupancy, 0);
    chk("R9 tail position", alloc_idx, 0);
  endtask

  task automatic t_squash_stop();
    do_alloc(50); do_alloc(51); do_alloc(52); do_alloc(53);
    do_exe(0, 'h700, 4, 'hE0, 1'b0, 1'b0);
    do_exe(1, 'h701, 4, 'hE1, 1'b0, 1'b0);
    do_exe(2, 'h702, 4, 'hE2, 1'b1, 1'b0);
    // slot 2 is eligible but blocked behind slot 0
    chk("R4 blocked behind older", wr_valid, 0);
    sqh_valid = 1'b1; sqh_seq = 8'd50; alloc_valid = 1'b1; alloc_seq = 8'd99;
    #1;
    chk("R11 alloc_ready low during squash", alloc_ready, 0);
    step();
    sqh_valid = 1'b0; alloc_valid = 1'b0;
    chk("R10 squash stops at eligible", occupancy, 3);
    chk("R10 tail pulled back", alloc_idx, 3);
    do_commit(50);
    chk("R3 commit stops at younger", wr_idx, 0);
    do_take();
    chk("R3 slot 1 not eligible", wr_valid, 0);
    do_done(0);
    chk("R12 after head done", occupancy, 2);
    do_squash(50);
    chk("R10 eligible tail blocks squash", occupancy, 2);
    chk("R10 tail unchanged", alloc_idx, 3);
    do_commit(51);
    chk("R10 survivor written", wr_idx, 1);
    chk("R10 survivor data", wr_data, 'hE1);
    do_take();
    chk("R4 conditional follows", wr_idx, 2);
    chk("R4 conditional data", wr_data, 'hE2);
    do_take();
    do_done(1); do_done(2);
    chk("R12 final empty", occupancy, 0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #23;
    rst_n = 1'b1;
    step();
    t_reset();
    t_fill_and_flush();
    t_commit_order();
    t_conditional();
    t_zero_and_prefetch();
    t_head_jump();
    t_squash_stop();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule